// File: doc/BRIEF.md
# First-Order Delta-Sigma Modulator with Quantizer Dither

This block turns a stream of signed 16-bit samples into a one-bit pulse-density stream. It works at the oversampled rate and takes one sample per clock enable. Each output bit stands for either plus or minus full scale. The loop is a single accumulating integrator followed by a sign quantizer. The quantizer decision is registered, then fed back as plus or minus 32768 and subtracted from the next sample. The running mean of the bit stream therefore follows the input divided by full scale.

A small pseudo-random term can be added to the integrator value just before the sign decision. This breaks up idle tones and limit cycles. The term never enters the accumulator or the input path. It comes from a 16-bit linear-feedback shift register that steps once per accepted sample. A decimation filter placed downstream recovers the signal. Inputs should stay strictly inside plus or minus full scale.

Top module: `dsm1_mod`

## Requirements
- R1: While `rst` is high at a clock edge, the accumulator and the feedback value clear to zero, the shift register loads 16'hACE1, and both `bit_out` and `bit_vld` are 0.
- R2: On each clock edge with `smp_en` high, the accumulator becomes its old value plus `smp_in` minus the held feedback value. The feedback value is 0 after reset and plus or minus 32768 afterwards.
- R3: `bit_out` becomes 1 when the new accumulator value plus the dither term is zero or positive, and 0 when that sum is negative.
- R4: The feedback value used by the next sample is +32768 when the last `bit_out` is 1 and -32768 when it is 0.
- R5: With `dith_on` = 1, the dither term is the low 4 bits of the shift register read as a signed two's-complement number (-8 to +7). It is added only at the quantizer input and never changes the accumulator. With `dith_on` = 0 the term is zero.
- R6: The shift register shifts left by one on each enabled sample only. Its new bit 0 is the XOR of bits 15, 14, 12 and 3. The dither for a sample uses the state held before that sample's shift.
- R7: When the sum from R2 lies outside the signed accumulator range (20 bits by default), the accumulator clamps to the most positive or most negative code instead of wrapping.
- R8: `bit_out` and `bit_vld` update on the clock edge that accepts an enabled sample. `bit_vld` is 1 for exactly the cycle after each accepted sample. While `smp_en` is low, `bit_out`, the accumulator and the shift register hold their values.
- R9: For a constant input k, the number of 1 bits over 2048 samples after reset is within 8 of 2048·(k+32768)/65536. This holds with the dither on and with it off.
- R10: With a zero input and the dither on, the output keeps toggling, but it no longer follows the strict 1,0,1,0 cycle that the undithered loop produces.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at the oversampled rate |
| rst | input | 1 | Synchronous reset, active high |
| smp_en | input | 1 | Accepts `smp_in` on this edge and steps the loop |
| smp_in | input | 16 | Signed two's-complement input sample |
| dith_on | input | 1 | Enables the dither term ahead of the quantizer |
| bit_out | output | 1 | Modulator bit: 1 = +full scale, 0 = -full scale |
| bit_vld | output | 1 | High for one cycle after each accepted sample |

## Verification
Every result of this block is due one clock edge after the sample that produced it. The edge that accepts a sample updates `bit_out`, `bit_vld`, the accumulator, the feedback value and the shift register together. The bench drives each sample on a falling edge and compares the outputs on the next falling edge. At that point the rising edge in between has updated all registers, and no input has changed yet. For hold checks the bench samples at falling edges while the enable is low, and confirms that the next accepted sample continues the reference sequence as if no gap had occurred.

// File: rtl/dsm1_pkg.sv
package dsm1_pkg;
  typedef enum logic {SGN_NEG = 1'b0, SGN_POS = 1'b1} sgn_e;
  localparam int unsigned LFSR_W = 16;
  // feedback taps at bit positions 15, 14, 12, 3
  localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'hD008;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;
endpackage

// File: rtl/dsm1_lfsr.sv
module dsm1_lfsr #(
  parameter int unsigned W      = 16,
  parameter int unsigned OUT_W  = 4,
  parameter logic [W-1:0] TAPS  = '1,
  parameter logic [W-1:0] SEED  = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  output logic [OUT_W-1:0] rnd
);
  logic [W-1:0] state_q;

  function automatic logic [W-1:0] next_state(input logic [W-1:0] s);
    return {s[W-2:0], ^(s & TAPS)};
  endfunction

  always_ff @(posedge clk) begin
    if (rst)      state_q <= SEED;
    else if (adv) state_q <= next_state(state_q);
  end

  assign rnd = state_q[OUT_W-1:0];
endmodule

// File: rtl/dsm1_integ.sv
module dsm1_integ #(
  parameter int unsigned IN_W  = 16,
  parameter int unsigned ACC_W = 20
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic signed [IN_W-1:0]  x,
  input  logic signed [IN_W:0]    fb,
  output logic signed [ACC_W-1:0] acc_nxt,
  output logic signed [ACC_W-1:0] acc_q
);
  localparam int unsigned ERR_W = IN_W + 2;
  localparam int unsigned SUM_W = ((ACC_W > ERR_W) ? ACC_W : ERR_W) + 1;
  localparam logic signed [SUM_W-1:0] HI_S =
    $signed({{(SUM_W-ACC_W+1){1'b0}}, {(ACC_W-1){1'b1}}});
  localparam logic signed [SUM_W-1:0] LO_S =
    $signed({{(SUM_W-ACC_W+1){1'b1}}, {(ACC_W-1){1'b0}}});

  logic signed [SUM_W-1:0] sum;

  function automatic logic signed [ACC_W-1:0] clamp(input logic signed [SUM_W-1:0] s);
    if (s > HI_S)      return HI_S[ACC_W-1:0];
    else if (s < LO_S) return LO_S[ACC_W-1:0];
    else               return s[ACC_W-1:0];
  endfunction

  assign sum     = SUM_W'(acc_q) + SUM_W'(x) - SUM_W'(fb);
  assign acc_nxt = clamp(sum);

  always_ff @(posedge clk) begin
    if (rst)     acc_q <= '0;
    else if (en) acc_q <= acc_nxt;
  end
endmodule

// File: rtl/dsm1_quant.sv
module dsm1_quant #(
  parameter int unsigned ACC_W  = 20,
  parameter int unsigned DITH_W = 4
) (
  input  logic signed [ACC_W-1:0]  acc_in,
  input  logic        [DITH_W-1:0] rnd,
  input  logic                     dith_on,
  output logic                     q_pos
);
  localparam int unsigned QW = ACC_W + 1;

  logic signed [DITH_W-1:0] dith_val;
  logic signed [QW-1:0]     qsum;

  assign dith_val = dith_on ? $signed(rnd) : '0;
  assign qsum     = QW'(acc_in) + QW'(dith_val);
  assign q_pos    = ~qsum[QW-1];
endmodule

// File: rtl/dsm1_mod.sv
module dsm1_mod #(
  parameter int unsigned IN_W   = 16,
  parameter int unsigned ACC_W  = 20,
  parameter int unsigned DITH_W = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   smp_en,
  input  logic signed [IN_W-1:0] smp_in,
  input  logic                   dith_on,
  output logic                   bit_out,
  output logic                   bit_vld
);
  import dsm1_pkg::*;

  localparam int unsigned FB_W = IN_W + 1;
  localparam logic signed [FB_W-1:0] FS_POS = $signed({2'b01, {(IN_W-1){1'b0}}});
  localparam logic signed [FB_W-1:0] FS_NEG = $signed({2'b11, {(IN_W-1){1'b0}}});

  logic signed [ACC_W-1:0] acc_nxt;
  logic signed [ACC_W-1:0] acc_q;
  logic signed [FB_W-1:0]  fb_q;
  logic [DITH_W-1:0]       lfsr_rnd;
  logic                    q_pos;
  sgn_e                    sgn_q;
  logic                    vld_q;

  dsm1_lfsr #(
    .W(LFSR_W), .OUT_W(DITH_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)
  ) u_lfsr (
    .clk(clk), .rst(rst), .adv(smp_en), .rnd(lfsr_rnd)
  );

  dsm1_integ #(.IN_W(IN_W), .ACC_W(ACC_W)) u_integ (
    .clk(clk), .rst(rst), .en(smp_en), .x(smp_in), .fb(fb_q),
    .acc_nxt(acc_nxt), .acc_q(acc_q)
  );

  dsm1_quant #(.ACC_W(ACC_W), .DITH_W(DITH_W)) u_quant (
    .acc_in(acc_nxt), .rnd(lfsr_rnd), .dith_on(dith_on), .q_pos(q_pos)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sgn_q <= SGN_NEG;
      fb_q  <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= smp_en;
      if (smp_en) begin
        sgn_q <= q_pos ? SGN_POS : SGN_NEG;
        fb_q  <= q_pos ? FS_POS : FS_NEG;
      end
    end
  end

  assign bit_out = (sgn_q == SGN_POS);
  assign bit_vld = vld_q;
endmodule

// File: rtl/dsm1_mod_chk.sv
module dsm1_mod_chk #(
  parameter int unsigned IN_W   = 16,
  parameter int unsigned ACC_W  = 20,
  parameter int unsigned DITH_W = 4
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    smp_en,
  input logic                    dith_on,
  input logic                    bit_out,
  input logic                    bit_vld,
  input logic signed [ACC_W-1:0] acc_q,
  input logic signed [IN_W:0]    fb_q,
  input logic [DITH_W-1:0]       lfsr_rnd
);
  localparam logic signed [IN_W:0] FB_P = $signed({2'b01, {(IN_W-1){1'b0}}});
  localparam logic signed [IN_W:0] FB_N = $signed({2'b11, {(IN_W-1){1'b0}}});

  AST_VLD_AFTER_EN: assert property (@(posedge clk) disable iff (rst) smp_en |=> bit_vld); // R8
  AST_VLD_IDLE_LOW: assert property (@(posedge clk) disable iff (rst) !smp_en |=> !bit_vld); // R8
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !smp_en |=> ($stable(bit_out) && $stable(acc_q))); // R8
  AST_LFSR_HOLD: assert property (@(posedge clk) disable iff (rst) !smp_en |=> $stable(lfsr_rnd)); // R6
  AST_FB_TRACKS_BIT: assert property (@(posedge clk) disable iff (rst)
    bit_vld |-> (fb_q == (bit_out ? FB_P : FB_N))); // R4
  AST_SIGN_NO_DITHER: assert property (@(posedge clk) disable iff (rst)
    (smp_en && !dith_on) |=> (bit_out == !acc_q[ACC_W-1])); // R3
endmodule

bind dsm1_mod dsm1_mod_chk #(.IN_W(IN_W), .ACC_W(ACC_W), .DITH_W(DITH_W)) u_chk (
  .clk(clk), .rst(rst), .smp_en(smp_en), .dith_on(dith_on),
  .bit_out(bit_out), .bit_vld(bit_vld), .acc_q(acc_q), .fb_q(fb_q),
  .lfsr_rnd(lfsr_rnd)
);

// File: tb/dsm1_mod_tb.sv
module dsm1_mod_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic               rst = 1'b1;
  logic               smp_en = 1'b0;
  logic               dith_on = 1'b0;
  logic signed [15:0] smp_in = '0;
  logic bit_out, bit_vld, bit_out_s, bit_vld_s;

  dsm1_mod u_dut (
    .clk(clk), .rst(rst), .smp_en(smp_en), .smp_in(smp_in), .dith_on(dith_on),
    .bit_out(bit_out), .bit_vld(bit_vld)
  );
  dsm1_mod #(.ACC_W(16)) u_sat (
    .clk(clk), .rst(rst), .smp_en(smp_en), .smp_in(smp_in), .dith_on(dith_on),
    .bit_out(bit_out_s), .bit_vld(bit_vld_s)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  // reference model state
  int          m_acc, m_fb, m_accw;
  logic [15:0] m_lfsr;

  localparam int NV = 8;
  localparam int NS = 2048;
  localparam int VK [NV] = '{0, 0, 16384, 16384, -16384, 30000, -30000, 1000};
  localparam bit VD [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1};
  localparam int VE [NV] = '{1024, 1024, 1536, 1536, 512, 1962, 87, 1055};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic m_step(input int x, output logic q);
    int d, s, hi, lo;
    d  = dith_on ? (m_lfsr[3] ? int'(m_lfsr[3:0]) - 16 : int'(m_lfsr[3:0])) : 0;
    hi = (1 << (m_accw - 1)) - 1;
    lo = -(1 << (m_accw - 1));
    s  = m_acc + x - m_fb;
    if (s > hi) s = hi;
    if (s < lo) s = lo;
    m_acc  = s;
    q      = ((s + d) >= 0);
    m_fb   = q ? 32768 : -32768;
    m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[14] ^ m_lfsr[12] ^ m_lfsr[3]};
  endtask

  task automatic do_reset(input int accw);
    rst = 1'b1;
    smp_en = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    m_acc = 0; m_fb = 0; m_lfsr = 16'hACE1; m_accw = accw;
  endtask

  // drive one enabled sample at a falling edge; outputs are due at the next falling edge
  task automatic step(input int x, output logic q_exp);
    smp_in = 16'(x);
    smp_en = 1'b1;
    @(negedge clk);
    m_step(x, q_exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      summary();
    end
  end

  initial begin
    logic e;
    int   bad, ones, togg, same, prev, b0;
    @(negedge clk);

    // R1: reset state
    do_reset(20);
    chk(bit_out === 1'b0, "R1 bit_out after reset", int'(bit_out), 0);
    chk(bit_vld === 1'b0, "R1 bit_vld after reset", int'(bit_vld), 0);

    // R1 R3: first zero sample with cleared accumulator and feedback gives a 1
    dith_on = 1'b0;
    step(0, e);
    chk(bit_out === 1'b1, "R1 R3 first zero sample", int'(bit_out), 1);
    chk(bit_vld === 1'b1, "R8 vld after sample", int'(bit_vld), 1);
    smp_en = 1'b0;
    @(negedge clk);
    chk(bit_vld === 1'b0, "R8 vld drops when idle", int'(bit_vld), 0);

    // vector table: DC level and dither mode, exact stream and mean
    for (int i = 0; i < NV; i++) begin
      dith_on = VD[i];
      do_reset(20);
      bad = 0; ones = 0;
      for (int j = 0; j < NS; j++) begin
        step(VK[i], e);
        if (bit_out !== e || bit_vld !== 1'b1) bad++;
        ones += int'(bit_out);
      end
      smp_en = 1'b0;
      chk(bad == 0, "R2 R3 R4 R5 R6 bit stream vs model", bad, 0);
      chk((ones - VE[i] <= 8) && (VE[i] - ones <= 8), "R9 DC mean ones count", ones, VE[i]);
    end

    // R10: zero input with dither toggles and breaks the plain alternation
    dith_on = 1'b1;
    do_reset(20);
    togg = 0; same = 0; prev = -1;
    for (int j = 0; j < 256; j++) begin
      step(0, e);
      if (prev >= 0) begin
        if (int'(bit_out) != prev) togg++;
        else same++;
      end
      prev = int'(bit_out);
    end
    smp_en = 1'b0;
    chk(togg >= 64, "R10 dithered zero input toggles", togg, 64);
    chk(same > 0, "R10 dithered pattern differs from alternation", same, 1);

    // R8 R6: gaps between samples leave outputs and loop state untouched
    dith_on = 1'b1;
    do_reset(20);
    step(5000, e);
    smp_en = 1'b0;
    b0 = int'(bit_out);
    bad = 0;
    for (int g = 0; g < 6; g++) begin
      @(negedge clk);
      if (int'(bit_out) != b0 || bit_vld !== 1'b0) bad++;
    end
    chk(bad == 0, "R8 outputs hold while enable low", bad, 0);
    bad = 0;
    for (int j = 0; j < 40; j++) begin
      step(5000 - 300 * j, e);
      if (bit_out !== e) bad++;
      smp_en = 1'b0;
      repeat (j % 3) @(negedge clk);
    end
    chk(bad == 0, "R6 R8 stream continues across gaps", bad, 0);

    // R7: narrow accumulator instance clamps instead of wrapping
    dith_on = 1'b0;
    do_reset(16);
    step(32767, e);
    chk(bit_out_s === 1'b1, "R7 sat step 1", int'(bit_out_s), 1);
    step(-32768, e);
    chk(bit_out_s === 1'b0, "R7 clamp at most negative code", int'(bit_out_s), 0);
    chk(bit_out_s === e, "R7 model agrees", int'(bit_out_s), int'(e));
    step(32767, e);
    chk(bit_out_s === 1'b1, "R7 recovery after clamp", int'(bit_out_s), 1);
    smp_en = 1'b0;

    // R1: reset mid-stream clears outputs
    rst = 1'b1;
    @(negedge clk);
    chk(bit_out === 1'b0 && bit_vld === 1'b0, "R1 reset mid-stream",
        int'({bit_out, bit_vld}), 0);
    rst = 1'b0;

    finished = 1'b1;
    summary();
  end
endmodule